// File: doc/BRIEF.md
# Stopwatch Timing Core with Last-Result Recall

This core times intervals up to 59:59.99 from a 1 MHz system clock. Two cascaded dividers produce single-cycle enables. The first enable paces a display scan. The second, slower enable is the hundredths tick. Three chained BCD stages hold hundredths (00–99), seconds (00–59) and minutes (00–59). Each stage passes a one-tick carry to the next stage when it wraps.

Three one-cycle, active-high pulses control the count: start, pause and clear. Clear outranks pause, and pause outranks counting. When a running count is paused, the six live digits are saved in a recall register. Raising the recall input shows that saved result in place of the live count.

The six digits are scanned across eight display positions of a common-anode seven-segment display. The digit select is active-low one-hot. Two of the positions stay blank.

Top module: `stopwatch_core`

## Requirements
- R1: The hundredths value advances once for every SCAN_DIV*TICK_DIV clock cycles while the core runs. After reset, ticks fall on the cycles counted from 0 whose index modulo SCAN_DIV*TICK_DIV equals SCAN_DIV*TICK_DIV-1.
- R2: Hundredths count 00 to 99 in BCD. The wrap from 99 to 00 advances the seconds by one.
- R3: Seconds count 00 to 59. Their wrap to 00 advances the minutes. Minutes count 00 to 59 and then wrap to 00.
- R4: No counting happens until a start pulse arrives. Counting begins in the cycle after the start pulse.
- R5: A pause pulse, or the paused state, holds all six digits. A pause pulse wins over a start pulse given in the same cycle. A later start pulse resumes counting from the held value.
- R6: A clear pulse zeroes all live digits. This holds while running, while paused, and when clear coincides with pause or start. Clear leaves the run state unchanged.
- R7: A pause pulse that arrives while running copies the live digits into the recall register. The copy uses the value held at that edge. A pause given while already paused leaves the recall register unchanged. Clear leaves the recall register unchanged.
- R8: While recall_i is 1, the display shows the recall register. While recall_i is 0, it shows the live count.
- R9: Segment codes are active-low, with bit 6 driving segment g and bit 0 driving segment a. The digits 0 to 9 encode as 0x40, 0x79, 0x24, 0x30, 0x19, 0x12, 0x02, 0x78, 0x00 and 0x10.
- R10: The scan index steps 0,1,…,7 and wraps, advancing every SCAN_DIV cycles. The digit select is ~(1<<index). Positions 0 to 5 show, in order: hundredths units, hundredths tens, seconds units, seconds tens, minutes units and minutes tens. Positions 6 and 7 output 0x7F.
- R11: Synchronous reset does the following:
  - It zeroes the live digits, the recall register, the dividers and the scan index, so the select reads 0xFE.
  - It leaves the core paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (1 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that starts or resumes counting |
| pause_i | input | 1 | One-cycle pulse that holds the count and saves the result |
| clear_i | input | 1 | One-cycle pulse that zeroes the live count |
| recall_i | input | 1 | Level input: 1 shows the saved result, 0 shows the live count |
| digit_sel_n_o | output | 8 | Active-low one-hot digit select |
| seg_n_o | output | 7 | Active-low segments, bit 6 = g, bit 0 = a |

## Verification
The bench builds the core with SCAN_DIV=2 and TICK_DIV=2, so a hundredths tick comes every four cycles and the scan moves every two cycles. These settings bring the hundredths-to-seconds carry and the seconds-to-minutes carry within a few tens of thousands of cycles, where an exact cycle-by-cycle reference can follow them. The minutes wrap from 59 back to 00 stays out of reach at any divider setting, so an in-line property on the minutes carry covers it.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef logic [3:0] bcd_t;
    typedef logic [6:0] seg_t;

    typedef struct packed {
        bcd_t min_t;
        bcd_t min_o;
        bcd_t sec_t;
        bcd_t sec_o;
        bcd_t hun_t;
        bcd_t hun_o;
    } sw_time_t;

    typedef enum logic {
        ST_PAUSED  = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;

    localparam int   NUM_POS    = 8;
    localparam int   NUM_DIGITS = 6;
    localparam int   POS_W      = $clog2(NUM_POS);
    localparam seg_t SEG_BLANK  = 7'h7F;

    // Active-low, bit 6 = g ... bit 0 = a
    function automatic seg_t bcd_to_seg(bcd_t d);
        case (d)
            4'd0:    return 7'b1000000;
            4'd1:    return 7'b1111001;
            4'd2:    return 7'b0100100;
            4'd3:    return 7'b0110000;
            4'd4:    return 7'b0011001;
            4'd5:    return 7'b0010010;
            4'd6:    return 7'b0000010;
            4'd7:    return 7'b1111000;
            4'd8:    return 7'b0000000;
            4'd9:    return 7'b0010000;
            default: return SEG_BLANK;
        endcase
    endfunction

    // Display position to digit: least significant digit on position 0
    function automatic bcd_t pick_digit(sw_time_t t, logic [POS_W-1:0] pos);
        case (pos)
            3'd0:    return t.hun_o;
            3'd1:    return t.hun_t;
            3'd2:    return t.sec_o;
            3'd3:    return t.sec_t;
            3'd4:    return t.min_o;
            3'd5:    return t.min_t;
            default: return 4'hF;
        endcase
    endfunction

endpackage

// File: rtl/sw_tick_gen.sv
module sw_tick_gen #(
    parameter int SCAN_DIV = 10,
    parameter int TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic scan_en,
    output logic tick_en
);
    localparam int SW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [SW-1:0] SCAN_LAST = SW'(SCAN_DIV - 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);

    logic [SW-1:0] scan_q;
    logic [TW-1:0] tick_q;

    assign scan_en = (scan_q == SCAN_LAST);
    assign tick_en = scan_en && (tick_q == TICK_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_q <= '0;
            tick_q <= '0;
        end else begin
            scan_q <= scan_en ? '0 : scan_q + 1'b1;
            if (scan_en)
                tick_q <= (tick_q == TICK_LAST) ? '0 : tick_q + 1'b1;
        end
    end

    AST_TICK_ON_SCAN: assert property (@(posedge clk) disable iff (rst)
        tick_en |-> scan_en) else $error("tick without scan enable"); // R1

endmodule

// File: rtl/sw_bcd_stage.sv
module sw_bcd_stage
    import sw_pkg::*;
#(
    parameter int TENS_MAX = 9,
    parameter int ONES_MAX = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output bcd_t tens_q,
    output bcd_t ones_q,
    output logic carry
);
    localparam bcd_t T_LAST = bcd_t'(TENS_MAX);
    localparam bcd_t O_LAST = bcd_t'(ONES_MAX);

    logic at_max;
    assign at_max = (tens_q == T_LAST) && (ones_q == O_LAST);
    assign carry  = step && at_max;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tens_q <= '0;
            ones_q <= '0;
        end else if (step) begin
            if (ones_q == O_LAST) begin
                ones_q <= '0;
                tens_q <= (tens_q == T_LAST) ? '0 : tens_q + 1'b1;
            end else begin
                ones_q <= ones_q + 1'b1;
            end
        end
    end

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (tens_q <= T_LAST) && (ones_q <= O_LAST)) else $error("digit out of range"); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (step && at_max) |=> (tens_q == '0 && ones_q == '0)) else $error("no wrap to zero"); // R3

endmodule

// File: rtl/sw_ctrl.sv
module sw_ctrl
    import sw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     pause,
    input  logic     clear,
    input  logic     tick,
    input  sw_time_t live,
    output logic     count_step,
    output logic     running,
    output sw_time_t recall_q
);
    run_state_e state_q;

    assign running    = (state_q == ST_RUNNING);
    assign count_step = running && !pause && !clear && tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_PAUSED;
            recall_q <= '0;
        end else begin
            if (pause && running)
                recall_q <= live;
            if (pause)
                state_q <= ST_PAUSED;
            else if (start)
                state_q <= ST_RUNNING;
        end
    end

    AST_RECALL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (pause && running) |=> (recall_q == $past(live))) else $error("recall not captured"); // R7
    AST_RECALL_KEPT: assert property (@(posedge clk) disable iff (rst)
        !(pause && running) |=> $stable(recall_q)) else $error("recall disturbed"); // R7
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (state_q == ST_PAUSED && recall_q == '0)) else $error("bad reset state"); // R11

endmodule

// File: rtl/sw_scan.sv
module sw_scan
    import sw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               scan_en,
    input  logic               show_recall,
    input  sw_time_t           live,
    input  sw_time_t           recall,
    output logic [NUM_POS-1:0] sel_n,
    output seg_t               seg_n
);
    logic [POS_W-1:0] idx_q;
    sw_time_t         src;

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (scan_en)
            idx_q <= idx_q + 1'b1;
    end

    assign src   = show_recall ? recall : live;
    assign sel_n = ~(NUM_POS'(1) << idx_q);

    always_comb begin
        if (int'(idx_q) < NUM_DIGITS)
            seg_n = bcd_to_seg(pick_digit(src, idx_q));
        else
            seg_n = SEG_BLANK;
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot(~sel_n)) else $error("select not one-hot"); // R10
    AST_BLANK_POS: assert property (@(posedge clk) disable iff (rst)
        (int'(idx_q) >= NUM_DIGITS) |-> (seg_n == SEG_BLANK)) else $error("unused position lit"); // R10
    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> (idx_q == POS_W'($past(idx_q) + 1'b1))) else $error("scan step wrong"); // R10

endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
    import sw_pkg::*;
#(
    parameter int SCAN_DIV = 10,
    parameter int TICK_DIV = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       pause_i,
    input  logic       clear_i,
    input  logic       recall_i,
    output logic [7:0] digit_sel_n_o,
    output logic [6:0] seg_n_o
);
    localparam int NUM_STAGES = 3;

    logic     scan_en, tick_en, count_step, running;
    sw_time_t live, recall;
    bcd_t     tens_w [NUM_STAGES];
    bcd_t     ones_w [NUM_STAGES];
    logic     step_w [NUM_STAGES];
    logic     carry_w[NUM_STAGES];

    sw_tick_gen #(.SCAN_DIV(SCAN_DIV), .TICK_DIV(TICK_DIV)) u_ticks (
        .clk(clk), .rst(rst), .scan_en(scan_en), .tick_en(tick_en)
    );

    sw_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start_i), .pause(pause_i), .clear(clear_i),
        .tick(tick_en), .live(live), .count_step(count_step),
        .running(running), .recall_q(recall)
    );

    // Stage 0: hundredths (99), stages 1 and 2: seconds and minutes (59)
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        localparam int TMAX = (g == 0) ? 9 : 5;
        if (g == 0) begin : g_first
            assign step_w[g] = count_step;
        end else begin : g_chain
            assign step_w[g] = carry_w[g-1];
        end
        sw_bcd_stage #(.TENS_MAX(TMAX), .ONES_MAX(9)) u_stage (
            .clk(clk), .rst(rst), .clear(clear_i), .step(step_w[g]),
            .tens_q(tens_w[g]), .ones_q(ones_w[g]), .carry(carry_w[g])
        );
    end

    assign live = '{min_t: tens_w[2], min_o: ones_w[2],
                    sec_t: tens_w[1], sec_o: ones_w[1],
                    hun_t: tens_w[0], hun_o: ones_w[0]};

    sw_scan u_scan (
        .clk(clk), .rst(rst), .scan_en(scan_en), .show_recall(recall_i),
        .live(live), .recall(recall), .sel_n(digit_sel_n_o), .seg_n(seg_n_o)
    );

    AST_PAUSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!running && !clear_i) |=> $stable(live)) else $error("count moved while paused"); // R5
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (live == '0)) else $error("clear did not zero"); // R6
    AST_MIN_WRAP: assert property (@(posedge clk) disable iff (rst)
        carry_w[2] |=> (live.min_t == '0 && live.min_o == '0)) else $error("minutes wrap"); // R3
    AST_NO_IDLE_COUNT: assert property (@(posedge clk) disable iff (rst)
        !running |-> !count_step) else $error("step while paused"); // R4

endmodule

// File: tb/tb_stopwatch_core.sv
module tb_stopwatch_core;

    localparam int S = 2;
    localparam int T = 2;
    localparam int P = S * T;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0, pause_i = 1'b0, clear_i = 1'b0, recall_i = 1'b0;
    logic [7:0] digit_sel_n_o;
    logic [6:0] seg_n_o;

    always #2 clk = ~clk;

    stopwatch_core #(.SCAN_DIV(S), .TICK_DIV(T)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .pause_i(pause_i),
        .clear_i(clear_i), .recall_i(recall_i),
        .digit_sel_n_o(digit_sel_n_o), .seg_n_o(seg_n_o)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference model built from the requirements
    int  m_e, m_h, m_s, m_m, r_h, r_s, r_m;
    bit  m_run;

    always @(posedge clk) begin
        if (rst) begin
            m_e = 0; m_h = 0; m_s = 0; m_m = 0; r_h = 0; r_s = 0; r_m = 0; m_run = 0;
        end else begin
            bit tick;
            tick = ((m_e % P) == P - 1);
            if (pause_i && m_run) begin
                r_h = m_h; r_s = m_s; r_m = m_m;
            end
            if (clear_i) begin
                m_h = 0; m_s = 0; m_m = 0;
            end else if (m_run && !pause_i && tick) begin
                m_h++;
                if (m_h == 100) begin m_h = 0; m_s++; end
                if (m_s == 60)  begin m_s = 0; m_m++; end
                if (m_m == 60)  m_m = 0;
            end
            if (pause_i) m_run = 0;
            else if (start_i) m_run = 1;
            m_e++;
        end
    end

    function automatic logic [6:0] enc(int d);
        case (d)
            0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
            4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
            8: return 7'h00; 9: return 7'h10;
            default: return 7'h7F;
        endcase
    endfunction

    typedef struct {
        string tag;
        int    h, s, m;
    } item_t;

    item_t sb_q[$];

    task automatic check(string tag, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected value and scans all eight positions
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                item_t it;
                int    dg[6];
                it = sb_q[0];
                dg = '{it.h % 10, it.h / 10, it.s % 10, it.s / 10, it.m % 10, it.m / 10};
                for (int k = 0; k < 8 * S * 4 && digit_sel_n_o != 8'hFE; k++) @(negedge clk);
                for (int p = 0; p < 8; p++) begin
                    logic [7:0] exp_sel;
                    logic [6:0] exp_seg;
                    exp_sel = ~(8'd1 << p);
                    if (p > 0) repeat (S) @(negedge clk);
                    check({it.tag, " R10 select"}, digit_sel_n_o == exp_sel,
                          int'(digit_sel_n_o), int'(exp_sel));
                    exp_seg = (p < 6) ? enc(dg[p]) : 7'h7F;
                    check({it.tag, " R9 segments"}, seg_n_o == exp_seg,
                          int'(seg_n_o), int'(exp_seg));
                end
                void'(sb_q.pop_front());
            end
        end
    end

    // Driver: pushes the model's expected value and waits for the monitor
    task automatic expect_display(string tag, bit use_recall);
        item_t it;
        @(negedge clk);
        recall_i = use_recall;
        @(negedge clk);
        it.tag = tag;
        if (use_recall) begin it.h = r_h; it.s = r_s; it.m = r_m; end
        else            begin it.h = m_h; it.s = m_s; it.m = m_m; end
        sb_q.push_back(it);
        while (sb_q.size() != 0) @(negedge clk);
        recall_i = 1'b0;
    endtask

    task automatic pulse(bit st, bit pa, bit cl);
        @(negedge clk);
        start_i = st; pause_i = pa; clear_i = cl;
        @(negedge clk);
        start_i = 0; pause_i = 0; clear_i = 0;
    endtask

    task automatic run_for(int n);
        pulse(1, 0, 0);
        repeat (n - 1) @(negedge clk);
        pulse(0, 1, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        check("R11 select after reset", digit_sel_n_o == 8'hFE, int'(digit_sel_n_o), 8'hFE);
        expect_display("R11 live zero", 0);
        expect_display("R11 recall zero", 1);

        repeat (40) @(negedge clk);
        expect_display("R4 idle without start", 0);

        run_for(3);
        expect_display("R1 short run", 0);
        run_for(41);
        expect_display("R1 exact tick count", 0);

        run_for(450);
        expect_display("R2 hundredths carry", 0);
        expect_display("R7 recall after pause", 1);
        repeat (100) @(negedge clk);
        expect_display("R5 held while paused", 0);
        expect_display("R8 recall shows saved", 1);
        expect_display("R8 live after recall", 0);

        pulse(1, 1, 0);
        repeat (20) @(negedge clk);
        expect_display("R5 pause beats start", 0);

        pulse(0, 0, 1);
        expect_display("R6 clear while paused", 0);
        pulse(0, 1, 0);
        expect_display("R7 pause while paused keeps recall", 1);

        pulse(1, 0, 0);
        repeat (200) @(negedge clk);
        pulse(0, 0, 1);
        repeat (37) @(negedge clk);
        pulse(0, 1, 0);
        expect_display("R6 clear while running", 0);
        expect_display("R7 recall after clear run", 1);

        pulse(1, 0, 0);
        repeat (60) @(negedge clk);
        pulse(0, 1, 1);
        expect_display("R6 clear with pause", 0);
        expect_display("R7 capture on clear with pause", 1);

        run_for(6000 * P + 1234);
        expect_display("R3 seconds into minutes", 0);
        check("R3 minute reached", m_m == 1, m_m, 1);
        expect_display("R8 recall long run", 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule